// File: doc/BRIEF.md
# Timer Compare Output Controller

This block watches a free-running 16-bit timer and compares its new value with three compare registers that software loads. The comparison runs only in the cycle when the timer advances. Each channel has a fixed action. Channel 0 drives selected low output pins high. Channel 1 drives selected low output pins low. Channel 2 flips two dedicated toggle flip-flops, and those flip-flops drive the two upper pins. Two masks choose which pins each action touches: a set mask, and a shared reset/toggle mask.

Every match latches a per-channel flag one cycle after the match. The flag stays set until software clears it. Each flag can raise an interrupt request through its own enable. Software can also write the low pin latch directly. The timer and the bus decoder that produces the write strobes sit outside this block.

Top module: `tmr_cmp_out`

## Requirements
- R1: Channel i matches only in a cycle where `tmr_inc_i` is 1 and `tmr_val_i` equals compare register i. A timer value equal to a compare register while `tmr_inc_i` is 0 has no effect.
- R2: The flag, pin and toggle effects of a match appear after the second rising edge following the match cycle. After the first rising edge the flag is still 0.
- R3: Flags are sticky. `flag_o[i]` clears only through `flag_clr_i[i]`. When a clear and a new match land on the same edge, the flag stays set.
- R4: `irq_o[i]` is 1 exactly when `flag_o[i]` and `irq_en_i[i]` are both 1.
- R5: A match on channel 0 sets pin b (b in 0..5) to 1 for every set-mask bit b that is 1.
- R6: A match on channel 1 clears pin b (b in 0..5) for every reset/toggle mask bit b that is 1. If channels 0 and 1 act on the same bit on the same edge, the clear wins.
- R7: A match on channel 2 inverts toggle flip-flop k (k in 0..1) when reset/toggle mask bit 6+k is 1. `tgl_o[k]` shows the flip-flop, and pin 6+k follows it.
- R8: A mask bit of 0 leaves its pin unchanged on a match, while the channel flag is still set.
- R9: `out_we_i` loads `out_wdata_i` into pins 0..5 on the next edge. A compare action on that same edge overrides the write for the bits it touches.
- R10: Reset clears the pins, toggle flip-flops, masks, flags and all compare registers to 0.
- R11: `cmp_we_i[i]` loads `cmp_wdata_i` into compare register i. `set_msk_we_i` loads `msk_wdata_i` into the set mask, and `rt_msk_we_i` loads it into the reset/toggle mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tmr_val_i | input | 16 | Timer value after the increment |
| tmr_inc_i | input | 1 | Timer advanced this cycle |
| cmp_we_i | input | 3 | Write strobe for each compare register |
| cmp_wdata_i | input | 16 | Compare register write data |
| set_msk_we_i | input | 1 | Set mask write strobe |
| rt_msk_we_i | input | 1 | Reset/toggle mask write strobe |
| msk_wdata_i | input | 8 | Mask write data |
| out_we_i | input | 1 | Software write strobe for pins 0..5 |
| out_wdata_i | input | 6 | Software pin data |
| flag_clr_i | input | 3 | Flag clear, one bit per channel |
| irq_en_i | input | 3 | Interrupt enable, one bit per channel |
| pin_o | output | 8 | Output pin states |
| tgl_o | output | 2 | Toggle flip-flop states |
| flag_o | output | 3 | Match flags |
| irq_o | output | 3 | Interrupt requests |

## Verification
Two kinds of collision can land on a single edge. The first is the set and clear actions hitting the same pin: channels 0 and 1 are loaded with the same value, so one timer step drives both on one bit, and the pin must read 0 afterwards. The second is a delayed compare action meeting a software pin write, with a flag clear arriving on the same edge as a fresh match. The bench times the write strobe and the clear to the edge where the match takes effect. It then checks that the masked bits follow the compare action and the other bits follow the written data. The new flag must survive the clear, and flags that had nothing to clear must read 0.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int unsigned N_CH   = 3;
  localparam int unsigned CH_SET = 0;
  localparam int unsigned CH_RST = 1;
  localparam int unsigned CH_TGL = 2;
endpackage

// File: rtl/cmp_match.sv
module cmp_match import cmp_pkg::*; #(
  parameter int unsigned TW = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [TW-1:0]            tmr_val_i,
  input  logic                     tmr_inc_i,
  input  logic [N_CH-1:0]          cmp_we_i,
  input  logic [TW-1:0]            cmp_wdata_i,
  output logic [N_CH-1:0]          hit_q_o
);
  logic [N_CH-1:0][TW-1:0] cmp_q;
  logic [N_CH-1:0]         hit;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          cmp_q[i] <= '0;
      else if (cmp_we_i[i]) cmp_q[i] <= cmp_wdata_i;
    end
    assign hit[i] = tmr_inc_i && (tmr_val_i == cmp_q[i]);
  end

  // one-cycle pipeline: effects land on the following edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_q_o <= '0;
    else         hit_q_o <= hit;
  end

  // R1
  idle_no_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tmr_inc_i |=> (hit_q_o == '0));
endmodule

// File: rtl/cmp_flags.sv
module cmp_flags import cmp_pkg::*; (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] hit_q_i,
  input  logic [N_CH-1:0] flag_clr_i,
  input  logic [N_CH-1:0] irq_en_i,
  output logic [N_CH-1:0] flag_o,
  output logic [N_CH-1:0] irq_o
);
  logic [N_CH-1:0] flag_q;

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~flag_clr_i) | hit_q_i;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & irq_en_i;

  for (genvar i = 0; i < N_CH; i++) begin : g_chk
    // R2
    flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_q_i[i] |=> flag_q[i]);
    // R3
    flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flag_q[i] && !flag_clr_i[i] |=> flag_q[i]);
  end
endmodule

// File: rtl/cmp_pins.sv
module cmp_pins import cmp_pkg::*; #(
  parameter int unsigned N_LAT = 6,
  parameter int unsigned N_TGL = 2,
  localparam int unsigned N_PIN = N_LAT + N_TGL
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CH-1:0]  hit_q_i,
  input  logic             set_msk_we_i,
  input  logic             rt_msk_we_i,
  input  logic [N_PIN-1:0] msk_wdata_i,
  input  logic             out_we_i,
  input  logic [N_LAT-1:0] out_wdata_i,
  output logic [N_PIN-1:0] pin_o,
  output logic [N_TGL-1:0] tgl_o
);
  logic [N_PIN-1:0] set_msk_q, rt_msk_q;
  logic [N_LAT-1:0] lat_q, lat_d;
  logic [N_TGL-1:0] tgl_q, tgl_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_msk_q <= '0;
      rt_msk_q  <= '0;
    end else begin
      if (set_msk_we_i) set_msk_q <= msk_wdata_i;
      if (rt_msk_we_i)  rt_msk_q  <= msk_wdata_i;
    end
  end

  // order: software write, then set, then clear (clear has last word)
  always_comb begin
    lat_d = out_we_i ? out_wdata_i : lat_q;
    for (int b = 0; b < N_LAT; b++) begin
      if (hit_q_i[CH_SET] && set_msk_q[b]) lat_d[b] = 1'b1;
      if (hit_q_i[CH_RST] && rt_msk_q[b])  lat_d[b] = 1'b0;
    end
  end

  always_comb begin
    tgl_d = tgl_q;
    for (int k = 0; k < N_TGL; k++)
      if (hit_q_i[CH_TGL] && rt_msk_q[N_LAT+k]) tgl_d[k] = ~tgl_q[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= '0;
      tgl_q <= '0;
    end else begin
      lat_q <= lat_d;
      tgl_q <= tgl_d;
    end
  end

  assign pin_o = {tgl_q, lat_q};
  assign tgl_o = tgl_q;

  for (genvar b = 0; b < N_LAT; b++) begin : g_lat_chk
    // R6
    clr_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_q_i[CH_RST] && rt_msk_q[b] |=> !lat_q[b]);
    // R5
    set_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_q_i[CH_SET] && set_msk_q[b] && !(hit_q_i[CH_RST] && rt_msk_q[b]) |=> lat_q[b]);
    // R8
    quiet_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !out_we_i && !(hit_q_i[CH_SET] && set_msk_q[b]) && !(hit_q_i[CH_RST] && rt_msk_q[b])
      |=> $stable(lat_q[b]));
  end

  for (genvar k = 0; k < N_TGL; k++) begin : g_tgl_chk
    // R7
    tgl_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_q_i[CH_TGL] && rt_msk_q[N_LAT+k] |=> (tgl_q[k] != $past(tgl_q[k])));
    // R8
    tgl_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(hit_q_i[CH_TGL] && rt_msk_q[N_LAT+k]) |=> $stable(tgl_q[k]));
  end
endmodule

// File: rtl/tmr_cmp_out.sv
module tmr_cmp_out import cmp_pkg::*; #(
  parameter int unsigned TW    = 16,
  parameter int unsigned N_LAT = 6,
  parameter int unsigned N_TGL = 2,
  localparam int unsigned N_PIN = N_LAT + N_TGL
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TW-1:0]    tmr_val_i,
  input  logic             tmr_inc_i,
  input  logic [N_CH-1:0]  cmp_we_i,
  input  logic [TW-1:0]    cmp_wdata_i,
  input  logic             set_msk_we_i,
  input  logic             rt_msk_we_i,
  input  logic [N_PIN-1:0] msk_wdata_i,
  input  logic             out_we_i,
  input  logic [N_LAT-1:0] out_wdata_i,
  input  logic [N_CH-1:0]  flag_clr_i,
  input  logic [N_CH-1:0]  irq_en_i,
  output logic [N_PIN-1:0] pin_o,
  output logic [N_TGL-1:0] tgl_o,
  output logic [N_CH-1:0]  flag_o,
  output logic [N_CH-1:0]  irq_o
);
  logic [N_CH-1:0] hit_q;

  cmp_match #(.TW(TW)) u_match (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tmr_val_i   (tmr_val_i),
    .tmr_inc_i   (tmr_inc_i),
    .cmp_we_i    (cmp_we_i),
    .cmp_wdata_i (cmp_wdata_i),
    .hit_q_o     (hit_q)
  );

  cmp_flags u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hit_q_i    (hit_q),
    .flag_clr_i (flag_clr_i),
    .irq_en_i   (irq_en_i),
    .flag_o     (flag_o),
    .irq_o      (irq_o)
  );

  cmp_pins #(.N_LAT(N_LAT), .N_TGL(N_TGL)) u_pins (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .hit_q_i      (hit_q),
    .set_msk_we_i (set_msk_we_i),
    .rt_msk_we_i  (rt_msk_we_i),
    .msk_wdata_i  (msk_wdata_i),
    .out_we_i     (out_we_i),
    .out_wdata_i  (out_wdata_i),
    .pin_o        (pin_o),
    .tgl_o        (tgl_o)
  );

  // R7
  tgl_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_o[N_PIN-1:N_LAT] == tgl_o);
  // R4
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_o[CH_SET] |-> !irq_o[CH_SET]);
endmodule

// File: tb/tb_tmr_cmp_out.sv
module tb_tmr_cmp_out;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] tmr_val = '0;
  logic        tmr_inc = 1'b0;
  logic [2:0]  cmp_we = '0;
  logic [15:0] cmp_wdata = '0;
  logic        set_msk_we = 1'b0, rt_msk_we = 1'b0;
  logic [7:0]  msk_wdata = '0;
  logic        out_we = 1'b0;
  logic [5:0]  out_wdata = '0;
  logic [2:0]  flag_clr = '0, irq_en = '0;
  logic [7:0]  pin;
  logic [1:0]  tgl;
  logic [2:0]  flag, irq;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  tmr_cmp_out dut (
    .clk_i(clk), .rst_ni(rst_ni), .tmr_val_i(tmr_val), .tmr_inc_i(tmr_inc),
    .cmp_we_i(cmp_we), .cmp_wdata_i(cmp_wdata), .set_msk_we_i(set_msk_we),
    .rt_msk_we_i(rt_msk_we), .msk_wdata_i(msk_wdata), .out_we_i(out_we),
    .out_wdata_i(out_wdata), .flag_clr_i(flag_clr), .irq_en_i(irq_en),
    .pin_o(pin), .tgl_o(tgl), .flag_o(flag), .irq_o(irq)
  );

  // {timer value, expected pins, expected flags}
  localparam logic [26:0] VEC [6] = '{
    {16'h0005, 8'h00, 3'b000},
    {16'h0010, 8'h2D, 3'b001},
    {16'h0020, 8'h29, 3'b010},
    {16'h0030, 8'hE9, 3'b100},
    {16'h0030, 8'h29, 3'b100},
    {16'h0011, 8'h29, 3'b000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_cmp(input int ch, input logic [15:0] v);
    @(negedge clk); cmp_we = 3'b001 << ch; cmp_wdata = v;
    @(negedge clk); cmp_we = '0;
  endtask

  task automatic wr_msk(input logic is_rt, input logic [7:0] v);
    @(negedge clk); set_msk_we = !is_rt; rt_msk_we = is_rt; msk_wdata = v;
    @(negedge clk); set_msk_we = 0; rt_msk_we = 0;
  endtask

  // one timer step; returns at the negedge after the effects land
  task automatic step(input logic [15:0] v);
    @(negedge clk); tmr_val = v; tmr_inc = 1;
    @(negedge clk); tmr_inc = 0;
    @(negedge clk);
  endtask

  task automatic clr_all;
    flag_clr = 3'b111;
    @(negedge clk); flag_clr = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 pins", pin, 8'h00);
    chk("R10 flags", flag, 3'b000);
    rst_ni = 1;
    @(negedge clk);

    // R11 load registers
    wr_cmp(0, 16'h0010);
    wr_cmp(1, 16'h0020);
    wr_cmp(2, 16'h0030);
    wr_msk(0, 8'h2D);
    wr_msk(1, 8'hC6);
    irq_en = 3'b101;

    // R5 R6 R7 R11 table walk
    foreach (VEC[i]) begin
      @(negedge clk); tmr_val = VEC[i][26:11]; tmr_inc = 1;
      @(negedge clk); tmr_inc = 0;
      chk("R2 flag not yet set", flag, 3'b000);
      @(negedge clk);
      chk("R5/R6/R7 pins", pin, VEC[i][10:3]);
      chk("R7 tgl", tgl, VEC[i][10:9]);
      chk("R11 flags", flag, VEC[i][2:0]);
      chk("R4 irq", irq, VEC[i][2:0] & irq_en);
      clr_all();
      chk("R3 cleared", flag, 3'b000);
    end

    // R9 software write
    @(negedge clk); out_we = 1; out_wdata = 6'h06;
    @(negedge clk); out_we = 0;
    chk("R9 sw write", pin, 8'h06);

    // R6 set/clear collision on bit 2
    wr_cmp(1, 16'h0010);
    step(16'h0010);
    chk("R6 clear wins", pin, 8'h29);
    chk("R6 flags", flag, 3'b011);
    chk("R4 irq", irq, 3'b001);
    clr_all();

    // R9 compare overrides write; R3 set beats clear
    wr_cmp(1, 16'h0020);
    @(negedge clk); tmr_val = 16'h0020; tmr_inc = 1;
    @(negedge clk); tmr_inc = 0; out_we = 1; out_wdata = 6'h3F; flag_clr = 3'b111;
    @(negedge clk); out_we = 0; flag_clr = '0;
    chk("R9 override", pin, 8'h39);
    chk("R3 set beats clear", flag, 3'b010);

    // R3 sticky
    repeat (5) @(negedge clk);
    chk("R3 sticky", flag, 3'b010);

    // R1 equal value without increment
    @(negedge clk); tmr_val = 16'h0030;
    repeat (3) @(negedge clk);
    chk("R1 no inc flag", flag, 3'b010);
    chk("R1 no inc tgl", tgl, 2'b00);

    // R8 zero mask
    wr_msk(1, 8'h00);
    step(16'h0030);
    chk("R8 tgl kept", tgl, 2'b00);
    chk("R8 pins kept", pin, 8'h39);
    chk("R8 flag set", flag, 3'b110);

    // R4 enable change
    @(negedge clk); irq_en = 3'b110;
    @(negedge clk);
    chk("R4 irq", irq, 3'b110);

    // R10 mid-run reset, compare regs back to zero
    rst_ni = 0;
    @(negedge clk);
    chk("R10 pins", pin, 8'h00);
    chk("R10 flags", flag, 3'b000);
    rst_ni = 1;
    step(16'h0000);
    chk("R10 cmp zero", flag, 3'b111);
    chk("R10 masks zero", pin, 8'h00);
    chk("R4 irq", irq, 3'b110);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule